// File: doc/BRIEF.md
# Interleaved Result Forwarder

This block sits between two converters running in dual interleaved operation and one channel of a downstream digital filter. It bypasses the DMA path. Each converter delivers its regular results through a strobe and a data word. The block buffers one result per converter. It then presents the results to the filter one at a time in strict master/slave alternation. Each transfer carries the low 16 bits of the result. When a transfer completes, the block pulses the end-of-conversion clear line of the converter that supplied it.

Forwarding is qualified by three configuration inputs: the dual-mode field, the packing-mode field and the forward-enable bit. While the qualification is false, the enable bit has no effect. Buffered results are then discarded and the alternation returns to the master. The filter paces the stream with a ready signal. A word stays on the output until ready is seen.

Top module: `ilv_fwd`

## Requirements
- R1: Forwarding is active only when dual_mode_i is 5'b00011 or 5'b00111, pack_mode_i is 2'b01 and fwd_en_i is 1. While it is inactive, flt_vld_o, mst_eoc_clr_o and slv_eoc_clr_o stay 0 and result strobes are not buffered.
- R2: After reset or after forwarding becomes active, the first word sent comes from the master. A slave result that arrives earlier is held until the master word has been sent.
- R3: Transfers alternate strictly: master, slave, master, slave, and so on.
- R4: flt_data_o carries bits [15:0] of the result register of the converter whose turn it is.
- R5: While flt_vld_o is 1 and flt_rdy_i is 0, flt_vld_o stays 1 and flt_data_o stays unchanged in the next cycle, as long as forwarding remains active.
- R6: A clear pulse is asserted combinationally for exactly the cycle in which flt_vld_o and flt_rdy_i are both 1. mst_eoc_clr_o fires for a master word and slv_eoc_clr_o for a slave word, and never both together.
- R7: A new result strobe for a converter whose previous result has not yet been sent is dropped. The buffered value is kept.
- R8: When forwarding becomes inactive, buffered results are discarded and the turn returns to the master.
- R9: After reset, flt_vld_o, mst_eoc_clr_o and slv_eoc_clr_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| dual_mode_i | input | 5 | Dual-converter mode field |
| pack_mode_i | input | 2 | Data packing mode field |
| fwd_en_i | input | 1 | Forward-to-filter enable |
| mst_vld_i | input | 1 | Master result strobe |
| mst_data_i | input | RES_W | Master result register |
| slv_vld_i | input | 1 | Slave result strobe |
| slv_data_i | input | RES_W | Slave result register |
| flt_rdy_i | input | 1 | Filter ready |
| flt_data_o | output | OUT_W | Word sent to the filter |
| flt_vld_o | output | 1 | Word valid |
| mst_eoc_clr_o | output | 1 | Master end-of-conversion clear pulse |
| slv_eoc_clr_o | output | 1 | Slave end-of-conversion clear pulse |

## Verification
The assertions assume that the configuration inputs change only between transfers. A change while a word is waiting is treated as deactivation, so the hold property applies only while the block stays active. They also assume that flt_rdy_i is a plain level with no dependency on clear pulses in the same cycle. The stimulus changes configuration only in dedicated deactivation steps. It drives every input just after a clock edge and holds it for a full cycle. It raises ready only after it has checked the held word, so that no combinational loop or mid-cycle glitch is ever presented.

// File: rtl/ilv_fwd_pkg.sv
package ilv_fwd_pkg;
  localparam logic [4:0] DUAL_ILV_A = 5'b00011;
  localparam logic [4:0] DUAL_ILV_B = 5'b00111;
  localparam logic [1:0] PACK_FLT   = 2'b01;

  typedef enum logic {SRC_MST = 1'b0, SRC_SLV = 1'b1} src_e;

  function automatic logic fwd_mode_ok(input logic [4:0] dual, input logic [1:0] pack);
    return ((dual == DUAL_ILV_A) || (dual == DUAL_ILV_B)) && (pack == PACK_FLT);
  endfunction
endpackage

// File: rtl/ilv_gate.sv
module ilv_gate
  import ilv_fwd_pkg::*;
(
  input  logic [4:0] dual_mode_i,
  input  logic [1:0] pack_mode_i,
  input  logic       fwd_en_i,
  output logic       active_o
);
  assign active_o = fwd_en_i && fwd_mode_ok(dual_mode_i, pack_mode_i);
endmodule

// File: rtl/ilv_slot.sv
module ilv_slot #(
  parameter int RES_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic             cap_i,
  input  logic [RES_W-1:0] data_i,
  input  logic             take_i,
  output logic             pend_o,
  output logic [RES_W-1:0] data_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_o <= 1'b0;
      data_o <= '0;
    end else if (flush_i) begin
      pend_o <= 1'b0;
    end else begin
      if (take_i) pend_o <= 1'b0;
      // a result landing on a still-pending slot is dropped
      if (cap_i && (!pend_o || take_i)) begin
        pend_o <= 1'b1;
        data_o <= data_i;
      end
    end
  end
endmodule

// File: rtl/ilv_sel.sv
module ilv_sel
  import ilv_fwd_pkg::*;
#(
  parameter int NSRC = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            active_i,
  input  logic [NSRC-1:0] pend_i,
  input  logic            rdy_i,
  output src_e            turn_o,
  output logic            vld_o,
  output logic [NSRC-1:0] take_o
);
  src_e turn_q;
  logic fire;

  assign turn_o = turn_q;
  assign vld_o  = active_i && pend_i[turn_q];
  assign fire   = vld_o && rdy_i;

  always_comb begin
    take_o = '0;
    take_o[turn_q] = fire;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        turn_q <= SRC_MST;
    else if (!active_i) turn_q <= SRC_MST;
    else if (fire)      turn_q <= (turn_q == SRC_MST) ? SRC_SLV : SRC_MST;
  end
endmodule

// File: rtl/ilv_fwd.sv
module ilv_fwd
  import ilv_fwd_pkg::*;
#(
  parameter int RES_W = 32,
  parameter int OUT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [4:0]       dual_mode_i,
  input  logic [1:0]       pack_mode_i,
  input  logic             fwd_en_i,
  input  logic             mst_vld_i,
  input  logic [RES_W-1:0] mst_data_i,
  input  logic             slv_vld_i,
  input  logic [RES_W-1:0] slv_data_i,
  input  logic             flt_rdy_i,
  output logic [OUT_W-1:0] flt_data_o,
  output logic             flt_vld_o,
  output logic             mst_eoc_clr_o,
  output logic             slv_eoc_clr_o
);
  localparam int NSRC = 2;

  logic             active;
  logic [NSRC-1:0]  cap, pend, take;
  logic [RES_W-1:0] din  [NSRC];
  logic [RES_W-1:0] hold [NSRC];
  src_e             turn;

  ilv_gate u_gate (
    .dual_mode_i (dual_mode_i),
    .pack_mode_i (pack_mode_i),
    .fwd_en_i    (fwd_en_i),
    .active_o    (active)
  );

  assign cap[SRC_MST] = active && mst_vld_i;
  assign cap[SRC_SLV] = active && slv_vld_i;
  assign din[SRC_MST] = mst_data_i;
  assign din[SRC_SLV] = slv_data_i;

  for (genvar g = 0; g < NSRC; g++) begin : g_slot
    ilv_slot #(.RES_W(RES_W)) u_slot (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .flush_i (!active),
      .cap_i   (cap[g]),
      .data_i  (din[g]),
      .take_i  (take[g]),
      .pend_o  (pend[g]),
      .data_o  (hold[g])
    );
  end

  ilv_sel #(.NSRC(NSRC)) u_sel (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .active_i (active),
    .pend_i   (pend),
    .rdy_i    (flt_rdy_i),
    .turn_o   (turn),
    .vld_o    (flt_vld_o),
    .take_o   (take)
  );

  assign flt_data_o    = hold[turn][OUT_W-1:0];
  assign mst_eoc_clr_o = take[SRC_MST];
  assign slv_eoc_clr_o = take[SRC_SLV];
endmodule

// File: rtl/ilv_fwd_chk.sv
module ilv_fwd_chk #(
  parameter int OUT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [4:0]       dual_mode_i,
  input logic [1:0]       pack_mode_i,
  input logic             fwd_en_i,
  input logic             flt_rdy_i,
  input logic [OUT_W-1:0] flt_data_o,
  input logic             flt_vld_o,
  input logic             mst_eoc_clr_o,
  input logic             slv_eoc_clr_o
);
  logic act, last_mst;
  assign act = fwd_en_i && ((dual_mode_i == 5'b00011) || (dual_mode_i == 5'b00111))
               && (pack_mode_i == 2'b01);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         last_mst <= 1'b0;
    else if (!act)       last_mst <= 1'b0;
    else if (mst_eoc_clr_o) last_mst <= 1'b1;
    else if (slv_eoc_clr_o) last_mst <= 1'b0;
  end

  AST_GATE_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !act |-> (!flt_vld_o && !mst_eoc_clr_o && !slv_eoc_clr_o)); // R1
  AST_HOLD_WORD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act && flt_vld_o && !flt_rdy_i) |=> (!act || (flt_vld_o && $stable(flt_data_o)))); // R5
  AST_CLR_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({mst_eoc_clr_o, slv_eoc_clr_o})); // R6
  AST_CLR_HS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mst_eoc_clr_o || slv_eoc_clr_o) |-> (flt_vld_o && flt_rdy_i)); // R6
  AST_HS_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flt_vld_o && flt_rdy_i) |-> (mst_eoc_clr_o || slv_eoc_clr_o)); // R6
  AST_SLV_AFTER_MST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slv_eoc_clr_o |-> last_mst); // R2
  AST_MST_AFTER_SLV: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mst_eoc_clr_o |-> !last_mst); // R3
endmodule

bind ilv_fwd ilv_fwd_chk #(.OUT_W(OUT_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .dual_mode_i   (dual_mode_i),
  .pack_mode_i   (pack_mode_i),
  .fwd_en_i      (fwd_en_i),
  .flt_rdy_i     (flt_rdy_i),
  .flt_data_o    (flt_data_o),
  .flt_vld_o     (flt_vld_o),
  .mst_eoc_clr_o (mst_eoc_clr_o),
  .slv_eoc_clr_o (slv_eoc_clr_o)
);

// File: tb/tb_ilv_fwd.sv
module tb_ilv_fwd;
  localparam int CLK_PERIOD = 10;
  localparam int RES_W = 32;
  localparam int OUT_W = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [4:0] dual = 5'b00011;
  logic [1:0] pack = 2'b01;
  logic en = 1'b0, mv = 1'b0, sv = 1'b0, rdy = 1'b0;
  logic [RES_W-1:0] md = '0, sd = '0;
  logic [OUT_W-1:0] fd;
  logic fv, mclr, sclr;
  int n_chk = 0, n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ilv_fwd #(.RES_W(RES_W), .OUT_W(OUT_W)) dut (
    .clk_i(clk), .rst_ni(rst_n), .dual_mode_i(dual), .pack_mode_i(pack),
    .fwd_en_i(en), .mst_vld_i(mv), .mst_data_i(md), .slv_vld_i(sv),
    .slv_data_i(sd), .flt_rdy_i(rdy), .flt_data_o(fd), .flt_vld_o(fv),
    .mst_eoc_clr_o(mclr), .slv_eoc_clr_o(sclr)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk); #1;
  endtask

  // out = {vld, mclr, sclr}
  function automatic logic [2:0] st();
    return {fv, mclr, sclr};
  endfunction

  task automatic push_m(input logic [RES_W-1:0] d);
    mv = 1'b1; md = d; cyc(); mv = 1'b0;
  endtask

  task automatic push_s(input logic [RES_W-1:0] d);
    sv = 1'b1; sd = d; cyc(); sv = 1'b0;
  endtask

  // handshake current word: check data and which clear fires
  task automatic take(input string req, input logic [OUT_W-1:0] exp_d, input logic is_mst);
    chk({req, " vld"}, {31'd0, fv}, 32'd1);
    chk({req, " data"}, {16'd0, fd}, {16'd0, exp_d});
    rdy = 1'b1; #1;
    chk({req, " clr"}, {29'd0, st()}, {29'd0, 1'b1, is_mst, !is_mst});
    cyc(); rdy = 1'b0; #1;
  endtask

  task automatic t_reset();
    chk("R9 reset", {29'd0, st()}, 32'd0);
  endtask

  task automatic t_gate();
    en = 1'b1; dual = 5'b00001; rdy = 1'b1;
    push_m(32'h0000_1111); #1;
    chk("R1 bad dual", {29'd0, st()}, 32'd0);
    dual = 5'b00011; pack = 2'b00; #1;
    chk("R1 bad pack not buffered", {29'd0, st()}, 32'd0);
    push_m(32'h0000_2222); #1;
    chk("R1 bad pack", {29'd0, st()}, 32'd0);
    pack = 2'b01; en = 1'b0;
    push_m(32'h0000_3333); #1;
    chk("R1 enable off", {29'd0, st()}, 32'd0);
    en = 1'b1; #1;
    chk("R1 nothing buffered while off", {29'd0, st()}, 32'd0);
    rdy = 1'b0; cyc();
  endtask

  task automatic t_order();
    push_s(32'hABCD_5A5A);
    chk("R2 slave held back", {31'd0, fv}, 32'd0);
    push_m(32'h1234_C3C3);
    take("R2 R4 master first", 16'hC3C3, 1'b1);
    take("R3 R4 slave second", 16'h5A5A, 1'b0);
    chk("R3 idle after pair", {29'd0, st()}, 32'd0);
  endtask

  task automatic t_hold();
    push_m(32'h0000_BEEF);
    for (int i = 0; i < 4; i++) begin
      chk("R5 held vld", {31'd0, fv}, 32'd1);
      chk("R5 held data", {16'd0, fd}, 32'h0000_BEEF);
      chk("R6 no clr without rdy", {30'd0, mclr, sclr}, 32'd0);
      cyc();
    end
    // R7: second master result while pending is dropped
    push_m(32'h0000_DEAD);
    chk("R7 data kept", {16'd0, fd}, 32'h0000_BEEF);
    take("R7 first kept", 16'hBEEF, 1'b1);
    chk("R7 no second master", {31'd0, fv}, 32'd0);
    push_s(32'h0000_0042);
    take("R3 slave after master", 16'h0042, 1'b0);
  endtask

  task automatic t_deact();
    push_m(32'h0000_7777);
    push_s(32'h0000_8888);
    take("R3 master", 16'h7777, 1'b1);
    chk("R3 slave waiting", {31'd0, fv}, 32'd1);
    en = 1'b0; #1;
    chk("R1 off drops vld", {29'd0, st()}, 32'd0);
    cyc(); en = 1'b1; #1;
    chk("R8 slave discarded", {31'd0, fv}, 32'd0);
    push_s(32'h0000_9999);
    chk("R8 turn back to master", {31'd0, fv}, 32'd0);
    push_m(32'h0000_AAAA);
    take("R8 master first", 16'hAAAA, 1'b1);
    take("R8 slave next", 16'h9999, 1'b0);
  endtask

  task automatic t_alt();
    dual = 5'b00111; cyc();
    for (int i = 0; i < 3; i++) begin
      push_s(32'hF000_0100 + i);
      push_m(32'h0F00_0200 + i);
      take("R3 alt master", 16'h0200 + 16'(i), 1'b1);
      take("R3 alt slave", 16'h0100 + 16'(i), 1'b0);
    end
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 20000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #2;
    t_reset();
    cyc(); rst_n = 1'b1; cyc();
    t_reset();
    t_gate();
    t_order();
    t_hold();
    t_deact();
    t_alt();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule